// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Fabric

The block is a small reprogrammable logic fabric. Six primary input pins feed an array of 26 lookup cells, each with five inputs. Every cell input has its own source selector, so it can take a primary pin, the output of any cell, or one of four flip-flops. Each flip-flop samples the output of the cell with the same number on every rising clock edge. Eight output pins each pick their driver through their own selector: a cell, a flip-flop, or constant zero.

The cell evaluation and the muxing are purely combinational, so a pin change reaches the outputs without waiting for a clock. Software, or a controller nearby, loads the fabric through a simple write-only port with a strobe, an address and a data word. The truth table of each cell is one 32-bit word. The cell output is the bit of that word that its five input values index, with input 0 as the least significant index bit.

Top module: `lut_fabric`

## Requirements
- R1: While reset is asserted and right after it is released, every truth table is zero and every selector holds 6'h3F, so all eight outputs read 0 for any pin pattern. Asserting reset clears the configuration and the flip-flops at once.
- R2: A cell input selector value of 0 to 5 feeds primary pin 0 to 5 into that cell input.
- R3: A cell input selector of 6'h3F, or any value above 35, makes that cell input read 0.
- R4: A cell output equals bit {in4,in3,in2,in1,in0} of its 32-bit truth word, where in0 is the value of cell input 0.
- R5: A cell input selector value of 6 to 31 feeds the output of cell 0 to 25 into that input, so cells can be chained.
- R6: A cell input selector value of 32 to 35 feeds flip-flop 0 to 3 into that input.
- R7: An output selector value n from 0 to 25 drives the output pin from cell n.
- R8: An output selector value from 26 to 29 drives the pin from flip-flop 0 to 3. Any value from 30 to 63 drives 0.
- R9: Flip-flop i loads the output of cell i on every rising clock edge, so the value shows one cycle later.
- R10: A write at address n (0 to 25) loads the truth word of cell n. A write at 0x20+k (k from 0 to 7) loads output selector k from data bits [5:0]. A write at 0x40+5*c+p loads input selector p of cell c from data bits [5:0]. Writes to any other address change nothing.
- R11: Primary pin changes reach the output pins in the same cycle, with no clock edge in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the flip-flops and the configuration registers |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released in sync with clk |
| pin_in | input | 6 | Primary input pins |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| pin_out | output | 8 | Output pins |

## Verification
The bench loads a chained configuration. In it, one cell feeds another, a third cell reads a flip-flop, and output selectors point at cells, at flip-flops, at a code past the flip-flop range, and at the unused code. A design that indexed the truth word in reverse bit order, or that mapped selector codes onto the wrong source, would miss the table of expected pin values. A flip-flop path that added an extra stage, or fed a neighbouring cell into a flip-flop, would show up one clock after each vector.

Directed tests then cover the following. Out-of-range input selectors must read zero, not wrap onto a pin. Writes to addresses just past each region must not alias onto real registers. Only the low six data bits may reach a selector. Asserting reset in the middle of a run must clear the outputs at once.

// File: rtl/lfab_pkg.sv
package lfab_pkg;
  localparam int LF_IN     = 6;
  localparam int LF_LUT    = 26;
  localparam int LF_FF     = 4;
  localparam int LF_OUT    = 8;
  localparam int LF_K      = 5;
  localparam int LF_SEL_W  = 6;
  localparam int LF_ADDR_W = 8;
  localparam int LF_DATA_W = 32;
  // configuration address map
  localparam int LF_TT_BASE   = 'h00;
  localparam int LF_OSEL_BASE = 'h20;
  localparam int LF_PSEL_BASE = 'h40;
endpackage

// File: rtl/lfab_cfg.sv
module lfab_cfg
  import lfab_pkg::*;
#(
  parameter int N_LUT  = LF_LUT,
  parameter int K      = LF_K,
  parameter int N_OUT  = LF_OUT,
  parameter int SEL_W  = LF_SEL_W,
  parameter int ADDR_W = LF_ADDR_W,
  parameter int DATA_W = LF_DATA_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [N_LUT*(1<<K)-1:0]      tt_flat,
  output logic [N_LUT*K*SEL_W-1:0]     psel_flat,
  output logic [N_OUT*SEL_W-1:0]       osel_flat
);
  localparam int TT_W   = 1 << K;
  localparam int N_PSEL = N_LUT * K;

  logic [TT_W-1:0]  tt_q   [N_LUT];
  logic [TT_W-1:0]  tt_d   [N_LUT];
  logic [SEL_W-1:0] ps_q   [N_PSEL];
  logic [SEL_W-1:0] ps_d   [N_PSEL];
  logic [SEL_W-1:0] os_q   [N_OUT];
  logic [SEL_W-1:0] os_d   [N_OUT];
  logic [N_LUT-1:0]  tt_we;
  logic [N_PSEL-1:0] ps_we;
  logic [N_OUT-1:0]  os_we;

  // address decode
  always_comb begin
    for (int i = 0; i < N_LUT; i++)
      tt_we[i] = we && (addr == ADDR_W'(LF_TT_BASE + i));
    for (int i = 0; i < N_PSEL; i++)
      ps_we[i] = we && (addr == ADDR_W'(LF_PSEL_BASE + i));
    for (int i = 0; i < N_OUT; i++)
      os_we[i] = we && (addr == ADDR_W'(LF_OSEL_BASE + i));
  end

  // next state
  always_comb begin
    for (int i = 0; i < N_LUT; i++)
      tt_d[i] = tt_we[i] ? wdata[TT_W-1:0] : tt_q[i];
    for (int i = 0; i < N_PSEL; i++)
      ps_d[i] = ps_we[i] ? wdata[SEL_W-1:0] : ps_q[i];
    for (int i = 0; i < N_OUT; i++)
      os_d[i] = os_we[i] ? wdata[SEL_W-1:0] : os_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_LUT; i++)  tt_q[i] <= '0;
      for (int i = 0; i < N_PSEL; i++) ps_q[i] <= '1;
      for (int i = 0; i < N_OUT; i++)  os_q[i] <= '1;
    end else begin
      for (int i = 0; i < N_LUT; i++)  tt_q[i] <= tt_d[i];
      for (int i = 0; i < N_PSEL; i++) ps_q[i] <= ps_d[i];
      for (int i = 0; i < N_OUT; i++)  os_q[i] <= os_d[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_LUT; g++) begin : g_tt
      assign tt_flat[g*TT_W +: TT_W] = tt_q[g];
      // R10
      tt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tt_we[g] |=> tt_q[g] == $past(wdata[TT_W-1:0]));
    end
    for (g = 0; g < N_PSEL; g++) begin : g_ps
      assign psel_flat[g*SEL_W +: SEL_W] = ps_q[g];
    end
    for (g = 0; g < N_OUT; g++) begin : g_os
      assign osel_flat[g*SEL_W +: SEL_W] = os_q[g];
      // R10
      osel_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(LF_OSEL_BASE + g)) |=> os_q[g] == $past(wdata[SEL_W-1:0]));
    end
  endgenerate

  // R10
  dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tt_we, ps_we, os_we}));

  // R1
  rst_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tt_flat == '0 && osel_flat == '1 && psel_flat == '1));
endmodule

// File: rtl/lfab_srcmux.sv
module lfab_srcmux #(
  parameter int N_SRC = 36,
  parameter int SEL_W = 6
) (
  input  logic [N_SRC-1:0] src,
  input  logic [SEL_W-1:0] sel,
  output logic             y
);
  // codes at or above N_SRC match no source and read 0
  always_comb begin
    y = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (sel == SEL_W'(i)) y = src[i];
  end
endmodule

// File: rtl/lfab_cell.sv
module lfab_cell #(
  parameter int N_SRC = 36,
  parameter int K     = 5,
  parameter int SEL_W = 6
) (
  input  logic [N_SRC-1:0]   src,
  input  logic [K*SEL_W-1:0] sel,
  input  logic [(1<<K)-1:0]  truth,
  output logic               y
);
  logic [K-1:0] idx;

  genvar p;
  generate
    for (p = 0; p < K; p++) begin : g_port
      lfab_srcmux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mux (
        .src (src),
        .sel (sel[p*SEL_W +: SEL_W]),
        .y   (idx[p])
      );
    end
  endgenerate

  assign y = truth[idx];
endmodule

// File: rtl/lfab_ffbank.sv
module lfab_ffbank #(
  parameter int N_FF = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_FF-1:0] d,
  output logic [N_FF-1:0] q
);
  logic [N_FF-1:0] q_d;

  always_comb q_d = d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  // R9
  ff_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> q == $past(d));
endmodule

// File: rtl/lfab_outmux.sv
module lfab_outmux #(
  parameter int N_LUT = 26,
  parameter int N_FF  = 4,
  parameter int SEL_W = 6
) (
  input  logic [N_LUT-1:0] lut,
  input  logic [N_FF-1:0]  ff,
  input  logic [SEL_W-1:0] sel,
  output logic             y
);
  always_comb begin
    y = 1'b0;
    for (int i = 0; i < N_LUT; i++)
      if (sel == SEL_W'(i)) y = lut[i];
    for (int i = 0; i < N_FF; i++)
      if (sel == SEL_W'(N_LUT + i)) y = ff[i];
  end
endmodule

// File: rtl/lut_fabric.sv
module lut_fabric
  import lfab_pkg::*;
#(
  parameter int N_IN   = LF_IN,
  parameter int N_LUT  = LF_LUT,
  parameter int N_FF   = LF_FF,
  parameter int N_OUT  = LF_OUT,
  parameter int K      = LF_K,
  parameter int SEL_W  = LF_SEL_W,
  parameter int ADDR_W = LF_ADDR_W,
  parameter int DATA_W = LF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   pin_in,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [N_OUT-1:0]  pin_out
);
  localparam int TT_W  = 1 << K;
  localparam int N_SRC = N_IN + N_LUT + N_FF;

  logic [1:0]               rst_sync;
  logic                     rst_int_n;
  logic [N_LUT*TT_W-1:0]    tt_flat;
  logic [N_LUT*K*SEL_W-1:0] psel_flat;
  logic [N_OUT*SEL_W-1:0]   osel_flat;
  logic [N_LUT-1:0]         lut_out;
  logic [N_FF-1:0]          ff_q;
  logic [N_SRC-1:0]         src;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  lfab_cfg #(
    .N_LUT(N_LUT), .K(K), .N_OUT(N_OUT), .SEL_W(SEL_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .tt_flat   (tt_flat),
    .psel_flat (psel_flat),
    .osel_flat (osel_flat)
  );

  // source order: pins, then cells, then flip-flops
  assign src = {ff_q, lut_out, pin_in};

  genvar c;
  generate
    for (c = 0; c < N_LUT; c++) begin : g_cell
      lfab_cell #(.N_SRC(N_SRC), .K(K), .SEL_W(SEL_W)) u_cell (
        .src   (src),
        .sel   (psel_flat[c*K*SEL_W +: K*SEL_W]),
        .truth (tt_flat[c*TT_W +: TT_W]),
        .y     (lut_out[c])
      );
      // R3
      unused_cell_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
        (psel_flat[c*K*SEL_W +: K*SEL_W] == '1) |-> lut_out[c] == tt_flat[c*TT_W]);
    end

    for (c = 0; c < N_OUT; c++) begin : g_out
      lfab_outmux #(.N_LUT(N_LUT), .N_FF(N_FF), .SEL_W(SEL_W)) u_omux (
        .lut (lut_out),
        .ff  (ff_q),
        .sel (osel_flat[c*SEL_W +: SEL_W]),
        .y   (pin_out[c])
      );
      // R8
      out_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
        (osel_flat[c*SEL_W +: SEL_W] >= SEL_W'(N_LUT + N_FF)) |-> pin_out[c] == 1'b0);
    end
  endgenerate

  lfab_ffbank #(.N_FF(N_FF)) u_ff (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (lut_out[N_FF-1:0]),
    .q     (ff_q)
  );
endmodule

// File: tb/lut_fabric_test.sv
module lut_fabric_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] pin_in;
  logic       cfg_we;
  logic [7:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic [7:0] pin_out;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  lut_fabric uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pin_out(pin_out)
  );

  // {pins[5:0], expected {cell2, cell1, cell0}}
  // cell0 = (pins[4:0]==10110), cell1 = pin5 ^ cell0, cell2 = parity(pins[2:0])
  localparam logic [8:0] VEC [10] = '{
    {6'b010110, 3'b011}, {6'b110110, 3'b001}, {6'b000000, 3'b000},
    {6'b100000, 3'b010}, {6'b000111, 3'b100}, {6'b100001, 3'b110},
    {6'b010111, 3'b100}, {6'b000110, 3'b000}, {6'b011110, 3'b000},
    {6'b110010, 3'b110}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(input logic [5:0] p);
    @(negedge clk);
    pin_in = p;
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pin_in = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    #1;
    check("R1 in reset", pin_out, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(6'b111111);
    check("R1 after reset", pin_out, 8'h00);
    wr(8'h20, 32'd0);               // out0 <- cell0, truth still zero
    drive(6'b010110);
    check("R1 zero truth", pin_out, 8'h00);

    // cell0: ports 0..4 = pins 0..4, single hit at index 22
    for (int p = 0; p < 5; p++) wr(8'(8'h40 + p), 32'(p));
    wr(8'h00, 32'h0040_0000);
    // cell1: port0 = pin5, port1 = cell0 (code 6), xor
    wr(8'h45, 32'd5);
    wr(8'h46, 32'd6);
    wr(8'h01, 32'h0000_0006);
    // cell2: ports 0..2 = pins 0..2, odd parity
    for (int p = 0; p < 3; p++) wr(8'(8'h4A + p), 32'(p));
    wr(8'h02, 32'h0000_0096);
    // cell3: port0 = flip-flop 0 (code 32), copy
    wr(8'h4F, 32'd32);
    wr(8'h03, 32'h0000_0002);
    // outputs
    wr(8'h21, 32'd1);
    wr(8'h22, 32'd2);
    wr(8'h23, 32'd26);
    wr(8'h24, 32'd27);
    wr(8'h25, 32'd30);
    wr(8'h27, 32'd3);

    foreach (VEC[i]) begin
      drive(VEC[i][8:3]);
      // R2 R4 R5 R7 R11: cells settle with no clock edge
      check("R4/R5 cells R2 R7 R11", {5'b0, pin_out[2:0]}, {5'b0, VEC[i][2:0]});
      // R8: code 30 and 63 drive 0
      check("R8 unused outputs", {6'b0, pin_out[6:5]}, 8'h00);
      @(negedge clk);
      // R9: flip-flops 0 and 1 show cells 0 and 1 one edge later; R6: cell3 reads ff0
      check("R9 ff capture", {6'b0, pin_out[4:3]}, {6'b0, VEC[i][1:0]});
      check("R6 cell from ff", {7'b0, pin_out[7]}, {7'b0, VEC[i][0]});
    end

    // R10: writes outside every region are ignored
    wr(8'h1A, 32'hFFFF_FFFF);
    wr(8'h28, 32'd0);
    wr(8'hC2, 32'd0);
    drive(6'b010110);
    check("R10 ignored writes", {5'b0, pin_out[2:0]}, 8'h03);
    check("R10 ignored writes out6", {7'b0, pin_out[6]}, 8'h00);
    // R10: only data bits [5:0] reach a selector
    wr(8'h25, 32'hFFFF_FFC0);
    drive(6'b010110);
    check("R10 sel low bits", {7'b0, pin_out[5]}, 8'h01);

    // R3: out-of-range code on cell0 port4 reads 0
    wr(8'h00, 32'h0000_0040);
    wr(8'h44, 32'd40);
    drive(6'b010110);
    check("R3 code 40 reads 0", {7'b0, pin_out[0]}, 8'h01);
    wr(8'h44, 32'h3F);
    drive(6'b010110);
    check("R3 code 3F reads 0", {7'b0, pin_out[0]}, 8'h01);
    drive(6'b000111);
    check("R3 other index", {7'b0, pin_out[0]}, 8'h00);

    // R8: flip-flop 2 via code 28, then code 45 drives 0
    wr(8'h21, 32'd28);
    drive(6'b000001);
    @(negedge clk);
    check("R8 ff2 output", {7'b0, pin_out[1]}, 8'h01);
    drive(6'b000011);
    @(negedge clk);
    check("R8 ff2 output low", {7'b0, pin_out[1]}, 8'h00);
    drive(6'b000001);
    @(negedge clk);
    wr(8'h21, 32'd45);
    #1;
    check("R8 code 45", {7'b0, pin_out[1]}, 8'h00);

    // R1: reset mid-run clears at once
    drive(6'b010110);
    check("R1 pre-reset", {7'b0, pin_out[0]}, 8'h01);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", pin_out, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(6'b010110);
    check("R1 config lost", pin_out, 8'h00);

    finish_run();
  end
endmodule